// File: doc/BRIEF.md
# Quarter-Rate I/Q Downconverter and Decimator

This block brings a carrier sampled at exactly four times its own frequency down to DC and reduces it to a slow stream of complex sums. A 60 kHz carrier sampled at 240 kHz is the intended case. A two-bit phase counter advances once per accepted sample. The counter's value decides whether each sample is passed, negated or dropped on the in-phase path and on the quadrature path, so the mixer needs no multipliers. Each path then feeds an integrate-and-dump accumulator. The default window is 8000 samples, which gives one complex result at 30 Hz.

The whole chain acts as one long boxcar FIR filter centred on the carrier, which is the same as a single DFT bin evaluated at that frequency. The input can be a single comparator bit or a 4-bit two's-complement word from a sigma-delta stage, chosen by the `IN_W` parameter. Magnitude, phase, bit timing and time-code decoding are handled by later stages.

Top module: `qdc_decim`

## Requirements
- R1: The in-phase weight is +1, 0, -1, 0 for phase values 0, 1, 2, 3. The first accepted sample after reset has phase 0, and each accepted sample advances the phase by one, modulo 4.
- R2: The quadrature weight is 0, +1, 0, -1 for phase values 0, 1, 2, 3.
- R3: With `IN_W` = 1, an input bit of 1 counts as +1 and a bit of 0 counts as -1. With `IN_W` = 4, the input is a two's-complement value from -8 to +7.
- R4: After every `WINDOW` accepted samples, `out_i` and `out_q` take the weighted sums of exactly those samples, including the last one. In the same cycle `out_valid` is high for exactly one cycle, which is the cycle after the clock edge that captured the last sample.
- R5: A cycle with `in_valid` low has no effect on the phase, the sample count or the running sums.
- R6: The phase counter is not reset at the end of a window. With a window that is not a multiple of 4, the next window starts at the phase that follows on.
- R7: The sums have enough bits for a full window of full-scale samples. That is 14 bits for 1-bit input and 17 bits for 4-bit input at the default window, and a full-scale window produces its exact value without wrap-around.
- R8: `out_i` and `out_q` hold their value between pulses. A synchronous reset clears the outputs, `out_valid`, the phase counter and the sample count.
- R9: A reset in the middle of a window discards the partial sums, and the next result covers only samples accepted after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; high for one accepted sample |
| in_sample | input | IN_W | Comparator bit or signed 4-bit sample |
| out_valid | output | 1 | One-cycle pulse when new sums are presented |
| out_i | output | ACC_W | Signed in-phase sum of the last window |
| out_q | output | ACC_W | Signed quadrature sum of the last window |

## Verification
The bench runs a 1-bit instance with an 18-sample window next to a default 4-bit instance. Because the short window is not a multiple of 4, a design that resets the phase at each dump gives wrong sums from the second window on. Random gaps in the strobe catch a design that advances the phase or count on idle cycles, since its sums then drift. A full window of the most negative weighted samples reaches -30000, which would wrap in an accumulator that is too narrow. Dropping or duplicating the boundary sample shifts every later result. A reset in mid-window exposes sums or counts that survive reset.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

  // Largest magnitude a single input sample can take after sign mapping.
  function automatic int full_scale(input int in_w);
    return (in_w == 1) ? 1 : (1 << (in_w - 1));
  endfunction

  // Signed width that holds window * full_scale without overflow.
  function automatic int sum_width(input int in_w, input int window);
    return $clog2(window * full_scale(in_w) + 1) + 1;
  endfunction

endpackage

// File: rtl/qdc_phase_gen.sv
module qdc_phase_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  output logic [1:0] ph
);

  // Free-running quarter-cycle phase, advanced once per accepted sample.
  always_ff @(posedge clk) begin
    if (rst)      ph <= 2'd0;
    else if (adv) ph <= ph + 2'd1;
  end

endmodule

// File: rtl/qdc_mixer.sv
module qdc_mixer #(
  parameter int IN_W = 4,
  parameter int CW   = IN_W + 1
) (
  input  logic [IN_W-1:0]       din,
  input  logic [1:0]            ph,
  output logic signed [CW-1:0]  mix_i,
  output logic signed [CW-1:0]  mix_q
);

  logic signed [CW-1:0] val;

  generate
    if (IN_W == 1) begin : g_bit
      // Comparator bit: 1 -> +1, 0 -> -1
      always_comb val = din[0] ? CW'(1) : {CW{1'b1}};
    end else begin : g_word
      always_comb val = {din[IN_W-1], din};
    end
  endgenerate

  // Pass, zero or negate: no multiplier needed at quarter-rate sampling.
  always_comb begin
    mix_i = '0;
    mix_q = '0;
    case (ph)
      2'd0: mix_i = val;
      2'd1: mix_q = val;
      2'd2: mix_i = -val;
      default: mix_q = -val;
    endcase
  end

endmodule

// File: rtl/qdc_integrator.sv
module qdc_integrator #(
  parameter int CW    = 5,
  parameter int ACC_W = 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    dump,
  input  logic signed [CW-1:0]    term,
  output logic signed [ACC_W-1:0] result
);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] total;

  always_comb total = acc + {{(ACC_W-CW){term[CW-1]}}, term};

  // Integrate and dump: the closing sample is included in the result.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      result <= '0;
    end else if (en) begin
      if (dump) begin
        result <= total;
        acc    <= '0;
      end else begin
        acc <= total;
      end
    end
  end

endmodule

// File: rtl/qdc_decim.sv
module qdc_decim
  import qdc_pkg::*;
#(
  parameter int IN_W   = 4,
  parameter int WINDOW = 8000,
  localparam int CW    = IN_W + 1,
  localparam int ACC_W = sum_width(IN_W, WINDOW),
  localparam int CNT_W = $clog2(WINDOW)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [IN_W-1:0]         in_sample,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_i,
  output logic signed [ACC_W-1:0] out_q
);

  logic [1:0]             ph;
  logic [CNT_W-1:0]       cnt;
  logic                   last;
  logic signed [CW-1:0]   terms [2];
  logic signed [ACC_W-1:0] sums [2];

  qdc_phase_gen u_phase (
    .clk (clk),
    .rst (rst),
    .adv (in_valid),
    .ph  (ph)
  );

  qdc_mixer #(.IN_W(IN_W), .CW(CW)) u_mix (
    .din   (in_sample),
    .ph    (ph),
    .mix_i (terms[0]),
    .mix_q (terms[1])
  );

  always_comb last = in_valid && (cnt == CNT_W'(WINDOW - 1));

  // Window position and result strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= last;
      if (in_valid) cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  generate
    for (genvar p = 0; p < 2; p++) begin : g_path
      qdc_integrator #(.CW(CW), .ACC_W(ACC_W)) u_int (
        .clk    (clk),
        .rst    (rst),
        .en     (in_valid),
        .dump   (last),
        .term   (terms[p]),
        .result (sums[p])
      );
    end
  endgenerate

  assign out_i = sums[0];
  assign out_q = sums[1];

endmodule

// File: rtl/qdc_decim_chk.sv
module qdc_decim_chk #(
  parameter int IN_W   = 4,
  parameter int WINDOW = 8000,
  parameter int ACC_W  = 17,
  parameter int CNT_W  = 13
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [1:0]              ph,
  input logic [CNT_W-1:0]        cnt,
  input logic                    out_valid,
  input logic signed [ACC_W-1:0] out_i,
  input logic signed [ACC_W-1:0] out_q
);

  localparam int LIM = WINDOW * qdc_pkg::full_scale(IN_W);

  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ph == $past(ph) + 2'd1);

  a_r5_idle_phase: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ph) && $stable(cnt));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r4_pulse_after_last: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid) && ($past(cnt) == CNT_W'(WINDOW - 1)) && (cnt == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_i) && $stable(out_q));

  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && out_i == '0 && out_q == '0 && ph == 2'd0);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_i <= LIM) && (out_i >= -LIM) && (out_q <= LIM) && (out_q >= -LIM));

endmodule

bind qdc_decim qdc_decim_chk #(
  .IN_W(IN_W), .WINDOW(WINDOW), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ph(ph), .cnt(cnt),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/qdc_decim_test.sv
module qdc_decim_test;
  import qdc_pkg::*;

  localparam int W0 = 8000;
  localparam int W1 = 18;
  localparam int A0 = sum_width(4, W0);
  localparam int A1 = sum_width(1, W1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [3:0] s4 = '0;
  logic s1 = 1'b0;

  logic ov0, ov1;
  logic signed [A0-1:0] oi0, oq0;
  logic signed [A1-1:0] oi1, oq1;

  always #10 clk = ~clk;

  qdc_decim #(.IN_W(4), .WINDOW(W0)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(s4),
    .out_valid(ov0), .out_i(oi0), .out_q(oq0)
  );

  qdc_decim #(.IN_W(1), .WINDOW(W1)) uut1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(s1),
    .out_valid(ov1), .out_i(oi1), .out_q(oq1)
  );

  int vectors = 0;
  int fails = 0;
  string req = "R8";
  bit done = 0;

  int m_ph[2], m_cnt[2], m_si[2], m_sq[2], m_ei[2], m_eq[2];
  bit m_ev[2];
  int win[2];

  function automatic int w_i(int p);
    return (p == 0) ? 1 : (p == 2) ? -1 : 0;
  endfunction

  function automatic int w_q(int p);
    return (p == 1) ? 1 : (p == 3) ? -1 : 0;
  endfunction

  task automatic check(string what, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 2; k++) begin
      m_ph[k] = 0; m_cnt[k] = 0; m_si[k] = 0; m_sq[k] = 0;
      m_ei[k] = 0; m_eq[k] = 0; m_ev[k] = 0;
    end
  endtask

  task automatic model_step(int k, bit v, int val);
    if (!v) begin
      m_ev[k] = 0;
      return;
    end
    m_si[k] += w_i(m_ph[k]) * val;
    m_sq[k] += w_q(m_ph[k]) * val;
    m_ph[k] = (m_ph[k] + 1) % 4;
    if (m_cnt[k] == win[k] - 1) begin
      m_ei[k] = m_si[k]; m_eq[k] = m_sq[k];
      m_si[k] = 0; m_sq[k] = 0; m_cnt[k] = 0; m_ev[k] = 1;
    end else begin
      m_cnt[k]++;
      m_ev[k] = 0;
    end
  endtask

  // Called at a falling edge; drives, steps the model, checks at the next falling edge.
  task automatic tick(bit v, int v4, bit b);
    in_valid = v;
    s4 = v4[3:0];
    s1 = b;
    model_step(0, v, v4);
    model_step(1, v, b ? 1 : -1);
    @(posedge clk);
    @(negedge clk);
    check("valid4", int'(ov0), int'(m_ev[0]));
    check("valid1", int'(ov1), int'(m_ev[1]));
    check("i4", int'(oi0), m_ei[0]);
    check("q4", int'(oq0), m_eq[0]);
    check("i1", int'(oi1), m_ei[1]);
    check("q1", int'(oq1), m_eq[1]);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    model_clear();
    req = "R8";
    check("reset valid4", int'(ov0), 0);
    check("reset i4", int'(oi0), 0);
    check("reset q4", int'(oq0), 0);
    check("reset valid1", int'(ov1), 0);
    check("reset i1", int'(oi1), 0);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    win[0] = W0;
    win[1] = W1;
    model_clear();
    @(negedge clk);
    do_reset();

    // R1: constant positive bit, constant most-negative word
    req = "R1";
    for (int n = 0; n < 36; n++) tick(1'b1, -8, 1'b1);

    // R2 R6: quadrature-only pattern; 18-sample window rolls the phase
    req = "R2 R6";
    for (int n = 0; n < 54; n++) tick(1'b1, (n % 4 == 1) ? 7 : 0, (n % 4 == 1));

    // R3: zero bits map to -1, mixed signed words
    req = "R3";
    for (int n = 0; n < 36; n++) tick(1'b1, (n % 3) - 1, 1'b0);

    // R5: idle cycles interleaved with samples
    req = "R5";
    for (int n = 0; n < 300; n++)
      tick(($urandom % 3) == 0, int'($urandom % 16) - 8, $urandom % 2);

    // R9: reset with both instances part-way through a window
    for (int n = 0; n < 7; n++) tick(1'b1, 5, 1'b1);
    do_reset();
    req = "R9";
    for (int n = 0; n < 36; n++) tick(1'b1, 3, 1'b1);

    // R7: full-scale window, expected sums are -30000 on both paths
    do_reset();
    req = "R7";
    for (int n = 0; n < W0; n++) tick(1'b1, (n % 4 < 2) ? -8 : 7, (n % 4 < 2));
    check("fullscale i4", int'(oi0), -30000);
    check("fullscale q4", int'(oq0), -30000);

    // R4: random strobes and samples across several windows
    req = "R4";
    for (int n = 0; n < 24000; n++)
      tick(($urandom % 4) != 0, int'($urandom % 16) - 8, $urandom % 2);

    finish_run();
  end

endmodule